// File: doc/BRIEF.md
# ADC Acquisition Pacing Controller

This block decides when an analog-to-digital conversion starts, collects the results and tells the host when to act. There are three ways to start a conversion. A software write to a dedicated register address starts one. An internal pacer, built as a chain of two 16-bit down-counters stepped by a 10 MHz reference tick, starts one every period. An external pacer input starts one on each of its rising edges. The converter itself is outside the block. The block sends it a one-cycle start pulse and takes back a one-cycle done strobe with a data word. Each returned word goes into a 512-entry sample FIFO.

Conversions only run while a non-zero trigger source is programmed. An optional arm bit holds them off until a rising edge arrives on the trigger input. A sample target ends the acquisition. The block latches three flags: overrun, FIFO half-full and end-of-acquisition. It builds one interrupt from a general enable with a source selector, plus a dedicated end-of-acquisition enable.

The register bus is write-only and has eight addresses. Address 0 is control. Its bits are: [1:0] pacer source, [3:2] trigger source, [4] trigger arm, [5] end-of-acquisition interrupt enable, [6] general interrupt enable, [8:7] general source select. The other addresses are: 1 low divisor, 2 high divisor, 3 sample target, 4 flag clear, 5 FIFO flush, 6 software conversion.

Top module: `adc_pace_ctrl`

## Requirements
- R1: After reset there are no start pulses, the FIFO is empty, all flags and the interrupt are 0 and the idle status is 1.
- R2: While the trigger source field (control bits [3:2]) is 00, no conversion starts from any pacer source.
- R3: With pacer source 00 (software), each write to address 6 produces exactly one start pulse on the cycle after the write, whatever the data. Writes to address 6 in other pacer modes start nothing.
- R4: With pacer source 01, starts occur every L*H reference ticks, where L and H are the low and high divisors. A divisor of 0 counts as 65536.
- R5: With pacer source 10, each rising edge of the external pacer input starts one conversion.
- R6: When the arm bit (control bit 4) is set, no conversion starts until a rising edge of the trigger input. Any control write disarms the block.
- R7: A start request that arrives while a conversion is in flight produces no start and latches the overrun flag.
- R8: Returned words leave the FIFO oldest first. The FIFO holds 512 words. A word returned while the FIFO is full is dropped and latches the overrun flag.
- R9: The half-full flag latches once the FIFO holds more than 255 words. It stays set until cleared, even after the FIFO drains.
- R10: Once the programmed number of samples has been stored, the end-of-acquisition flag latches and no further starts are issued. A target of 0 counts as 65536.
- R11: The interrupt equals (general enable AND selected source) OR (end-of-acquisition enable AND end-of-acquisition flag). Source select values are: 00 half-full, 01 overrun, 10 end-of-acquisition, 11 FIFO not empty.
- R12: A write to address 4 clears the half-full flag (bit 0), the end-of-acquisition flag (bit 1) and the overrun flag (bit 2). A write to address 5 empties the FIFO and restarts sample counting.
- R13: The idle status output is low from the start pulse until the converter's done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| ref_tick | input | 1 | One-cycle strobe at the 10 MHz reference rate |
| ext_pace | input | 1 | External pacer input (rising edge) |
| trig_in | input | 1 | External digital trigger input |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_done | input | 1 | One-cycle converter done strobe |
| conv_data | input | 16 | Converter result word |
| fifo_rd | input | 1 | Pop the oldest FIFO word |
| fifo_dout | output | 16 | Oldest FIFO word |
| fifo_count | output | 10 | Words held in the FIFO |
| fifo_empty | output | 1 | FIFO holds nothing |
| hf_flag | output | 1 | Latched half-full flag |
| eoa_flag | output | 1 | Latched end-of-acquisition flag |
| ovr_flag | output | 1 | Latched overrun flag |
| eoc | output | 1 | Live idle status of the converter |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes the converter behaves well. It raises done for exactly one cycle, only after a start pulse, and never in the same cycle as a new start request. It also assumes that writes to address 4 are the only way the half-full flag can fall. The bench converter answers every start after a fixed six-cycle latency. Software and external requests are spaced wider than that latency, except in the one deliberate overrun case. The trigger source is returned to 00 before divisors or the pacer source are reprogrammed.

// File: rtl/adc_pace_pkg.sv
package adc_pace_pkg;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_DIVLO  = 3'd1,
        RA_DIVHI  = 3'd2,
        RA_COUNT  = 3'd3,
        RA_CLEAR  = 3'd4,
        RA_FLUSH  = 3'd5,
        RA_SWCONV = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        PS_SOFT = 2'd0,
        PS_INT  = 2'd1,
        PS_EXT  = 2'd2,
        PS_NONE = 2'd3
    } pace_src_e;

    typedef enum logic [1:0] {
        IS_HALF = 2'd0,
        IS_OVR  = 2'd1,
        IS_EOA  = 2'd2,
        IS_DATA = 2'd3
    } irq_sel_e;

    // Packed MSB first: [8:7] sel, [6] irq_en, [5] eoa_ie, [4] arm, [3:2] trig, [1:0] pace
    typedef struct packed {
        irq_sel_e   irq_sel;
        logic       irq_en;
        logic       eoa_ie;
        logic       arm_en;
        logic [1:0] trig_src;
        pace_src_e  pace_src;
    } ctrl_t;

endpackage

// File: rtl/adc_pace_stage.sv
module adc_pace_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] div,
    output logic         tc
);
    localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

    logic [W:0] cnt_q, cnt_d, reload;

    // A divisor of zero means the full 2^W count.
    assign reload = (div == '0) ? {1'b1, {W{1'b0}}} : {1'b0, div};
    assign tc     = step & (cnt_q == ONE);

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = reload;
        else if (step)
            cnt_d = (cnt_q == ONE) ? reload : cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= {1'b1, {W{1'b0}}};
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_pacer.sv
module adc_pacer #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                tick,
    input  logic [STAGES*W-1:0] div,
    output logic                fire
);
    logic [STAGES:0] chain;

    assign chain[0] = tick & run;

    // Each stage's terminal count steps the next stage.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        adc_pace_stage #(.W(W)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .load (~run),
            .step (chain[g]),
            .div  (div[g*W +: W]),
            .tc   (chain[g+1])
        );
    end

    assign fire = chain[STAGES];
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == FULL_C);
    assign empty   = (cnt_q == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/adc_pace_ctrl.sv
module adc_pace_ctrl
    import adc_pace_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 512,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DIV_W-1:0]  wr_data,
    input  logic              ref_tick,
    input  logic              ext_pace,
    input  logic              trig_in,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              fifo_rd,
    output logic [DATA_W-1:0] fifo_dout,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_empty,
    output logic              hf_flag,
    output logic              eoa_flag,
    output logic              ovr_flag,
    output logic              eoc,
    output logic              irq
);
    localparam int             PACE_STAGES = 2;
    localparam logic [CNT_W-1:0] HALF_C    = CNT_W'(FIFO_DEPTH / 2);
    localparam logic [DIV_W:0] ONE_S       = {{DIV_W{1'b0}}, 1'b1};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [DIV_W-1:0] div_lo;
        logic [DIV_W-1:0] div_hi;
        logic [DIV_W-1:0] target;
        logic             busy;
        logic [DIV_W:0]   issued;
        logic [DIV_W:0]   stored;
        logic             hf;
        logic             eoa;
        logic             ovr;
        logic             armed;
        logic             trig_prev;
        logic             ext_prev;
        logic             start;
    } st_t;

    st_t s_q, s_d;

    logic w_ctrl, w_lo, w_hi, w_cnt, w_clr, w_flush, w_sw;
    logic [DIV_W:0] target_eff;
    logic [1:0] trig_src_w;
    logic irq_en_w, eoa_ie_w;
    logic gate_open, pace_run, pace_fire, ext_rise, req, accept;
    logic push_ok, eoa_hit, sel_flag, fifo_full;

    assign w_ctrl  = wr_en && (wr_addr == RA_CTRL);
    assign w_lo    = wr_en && (wr_addr == RA_DIVLO);
    assign w_hi    = wr_en && (wr_addr == RA_DIVHI);
    assign w_cnt   = wr_en && (wr_addr == RA_COUNT);
    assign w_clr   = wr_en && (wr_addr == RA_CLEAR);
    assign w_flush = wr_en && (wr_addr == RA_FLUSH);
    assign w_sw    = wr_en && (wr_addr == RA_SWCONV);

    assign trig_src_w = s_q.ctrl.trig_src;
    assign irq_en_w   = s_q.ctrl.irq_en;
    assign eoa_ie_w   = s_q.ctrl.eoa_ie;

    assign target_eff = (s_q.target == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, s_q.target};
    assign gate_open  = (trig_src_w != 2'b00) && (!s_q.ctrl.arm_en || s_q.armed)
                        && (s_q.issued < target_eff);
    assign pace_run   = (s_q.ctrl.pace_src == PS_INT) && gate_open;
    assign ext_rise   = ext_pace & ~s_q.ext_prev;
    assign accept     = req & gate_open & ~s_q.busy;
    assign push_ok    = conv_done & ~fifo_full & ~w_flush;
    assign eoa_hit    = push_ok && ((s_q.stored + ONE_S) == target_eff);

    adc_pacer #(.W(DIV_W), .STAGES(PACE_STAGES)) u_pacer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (pace_run),
        .tick (ref_tick),
        .div  ({s_q.div_hi, s_q.div_lo}),
        .fire (pace_fire)
    );

    adc_sample_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(w_flush),
        .push (push_ok),
        .pop  (fifo_rd),
        .din  (conv_data),
        .dout (fifo_dout),
        .count(fifo_count),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    always_comb begin
        case (s_q.ctrl.pace_src)
            PS_SOFT: req = w_sw;
            PS_INT:  req = pace_fire;
            PS_EXT:  req = ext_rise;
            default: req = 1'b0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (w_ctrl) begin
            s_d.ctrl  = ctrl_t'(wr_data[8:0]);
            s_d.armed = 1'b0;
        end else if (s_q.ctrl.arm_en && trig_in && !s_q.trig_prev) begin
            s_d.armed = 1'b1;
        end
        if (w_lo)  s_d.div_lo = wr_data;
        if (w_hi)  s_d.div_hi = wr_data;
        if (w_cnt) s_d.target = wr_data;
        s_d.trig_prev = trig_in;
        s_d.ext_prev  = ext_pace;
        s_d.start     = accept;
        if (accept)         s_d.busy = 1'b1;
        else if (conv_done) s_d.busy = 1'b0;
        s_d.issued = w_flush ? '0 : s_q.issued + {{DIV_W{1'b0}}, accept};
        s_d.stored = w_flush ? '0 : s_q.stored + {{DIV_W{1'b0}}, push_ok};
        s_d.hf  = (s_q.hf  & ~(w_clr & wr_data[0])) | (fifo_count >= HALF_C);
        s_d.eoa = (s_q.eoa & ~(w_clr & wr_data[1])) | eoa_hit;
        s_d.ovr = (s_q.ovr & ~(w_clr & wr_data[2]))
                | (req & gate_open & s_q.busy)
                | (conv_done & fifo_full & ~w_flush);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (s_q.ctrl.irq_sel)
            IS_HALF: sel_flag = s_q.hf;
            IS_OVR:  sel_flag = s_q.ovr;
            IS_EOA:  sel_flag = s_q.eoa;
            default: sel_flag = ~fifo_empty;
        endcase
    end

    assign conv_start = s_q.start;
    assign hf_flag    = s_q.hf;
    assign eoa_flag   = s_q.eoa;
    assign ovr_flag   = s_q.ovr;
    assign eoc        = ~s_q.busy;
    assign irq        = (irq_en_w & sel_flag) | (eoa_ie_w & s_q.eoa);
endmodule

// File: rtl/adc_pace_ctrl_chk.sv
module adc_pace_ctrl_chk #(
    parameter int CNT_W = 10,
    parameter int DEPTH = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_hf,
    input logic             conv_start,
    input logic             conv_done,
    input logic             hf_flag,
    input logic             eoa_flag,
    input logic             eoc,
    input logic             irq,
    input logic [CNT_W-1:0] fifo_count,
    input logic [1:0]       trig_src,
    input logic             irq_en,
    input logic             eoa_ie
);
    // R3
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R2
    trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(trig_src) != 2'b00));

    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(eoc));

    // R9
    hf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hf_flag && !clr_hf) |=> hf_flag);

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R10
    eoa_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoa_flag) |-> $past(conv_done));

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !eoa_ie) |-> !irq);
endmodule

bind adc_pace_ctrl adc_pace_ctrl_chk #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_hf    (wr_en && (wr_addr == 3'd4) && wr_data[0]),
    .conv_start(conv_start),
    .conv_done (conv_done),
    .hf_flag   (hf_flag),
    .eoa_flag  (eoa_flag),
    .eoc       (eoc),
    .irq       (irq),
    .fifo_count(fifo_count),
    .trig_src  (trig_src_w),
    .irq_en    (irq_en_w),
    .eoa_ie    (eoa_ie_w)
);

// File: tb/adc_pace_ctrl_bench.sv
module adc_pace_ctrl_bench;
    localparam int LAT = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic        ref_tick = 0;
    logic        ext_pace = 0;
    logic        trig_in = 0;
    logic        conv_start;
    logic        conv_done = 0;
    logic [15:0] conv_data = 0;
    logic        fifo_rd = 0;
    logic [15:0] fifo_dout;
    logic [9:0]  fifo_count;
    logic        fifo_empty, hf_flag, eoa_flag, ovr_flag, eoc, irq;

    int n_chk = 0, n_fail = 0, n_starts = 0;
    bit fast_ref = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_pace_ctrl u_adc_pace_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_tick(ref_tick), .ext_pace(ext_pace), .trig_in(trig_in),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .fifo_rd(fifo_rd), .fifo_dout(fifo_dout), .fifo_count(fifo_count),
        .fifo_empty(fifo_empty), .hf_flag(hf_flag), .eoa_flag(eoa_flag),
        .ovr_flag(ovr_flag), .eoc(eoc), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference tick and converter stand-in
    int ref_cnt = 0;
    int cd = 0;
    int data_seq = 0;
    always @(negedge clk) begin
        ref_cnt  = (ref_cnt + 1) % 5;
        ref_tick <= fast_ref ? 1'b1 : (ref_cnt == 0);
        conv_done <= 1'b0;
        if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0) begin
                conv_done <= 1'b1;
                conv_data <= 16'(16'h1000 + data_seq * 7);
                data_seq++;
            end
        end
        if (conv_start) begin
            cd = LAT;
            n_starts++;
        end
    end

    // Behavioural reference model
    int m_src, m_trig, m_sel, m_lo, m_hi, m_tgt, m_iss, m_sto;
    bit m_arm, m_eoaie, m_irqen, m_busy, m_hf, m_eoa, m_ovr, m_armed, m_tprev, m_eprev, m_start;
    longint m_ticks;
    int mq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 0; m_trig = 0; m_sel = 0; m_lo = 0; m_hi = 0; m_tgt = 0;
            m_iss = 0; m_sto = 0; m_arm = 0; m_eoaie = 0; m_irqen = 0; m_busy = 0;
            m_hf = 0; m_eoa = 0; m_ovr = 0; m_armed = 0; m_tprev = 0; m_eprev = 0;
            m_start = 0; m_ticks = 0; mq.delete();
        end else begin
            longint per, nt;
            int lo_e, hi_e, tg_e, cnt;
            bit gate, run, hit, req, acc, flush, clrw, full, push, pop;
            bit hf_n, eoa_n, ovr_n;
            lo_e = (m_lo == 0) ? 65536 : m_lo;
            hi_e = (m_hi == 0) ? 65536 : m_hi;
            tg_e = (m_tgt == 0) ? 65536 : m_tgt;
            per  = longint'(lo_e) * longint'(hi_e);
            cnt  = mq.size();
            gate = (m_trig != 0) && (!m_arm || m_armed) && (m_iss < tg_e);
            run  = (m_src == 1) && gate;
            hit  = 0;
            if (run && ref_tick) begin
                nt  = m_ticks + 1;
                hit = (nt % per) == 0;
            end else begin
                nt = run ? m_ticks : 0;
            end
            req = (m_src == 0 && wr_en && wr_addr == 6) || (m_src == 1 && hit)
                  || (m_src == 2 && ext_pace && !m_eprev);
            acc   = req && gate && !m_busy;
            flush = wr_en && wr_addr == 5;
            clrw  = wr_en && wr_addr == 4;
            full  = (cnt == 512);
            push  = conv_done && !full && !flush;
            pop   = fifo_rd && cnt > 0 && !flush;
            hf_n  = (m_hf && !(clrw && wr_data[0])) || cnt >= 256;
            eoa_n = (m_eoa && !(clrw && wr_data[1])) || (push && m_sto + 1 == tg_e);
            ovr_n = (m_ovr && !(clrw && wr_data[2])) || (req && gate && m_busy)
                    || (conv_done && full && !flush);
            if (wr_en && wr_addr == 0) begin
                m_src = wr_data[1:0]; m_trig = wr_data[3:2]; m_arm = wr_data[4];
                m_eoaie = wr_data[5]; m_irqen = wr_data[6]; m_sel = wr_data[8:7];
                m_armed = 0;
            end else if (m_arm && trig_in && !m_tprev) begin
                m_armed = 1;
            end
            if (wr_en && wr_addr == 1) m_lo = wr_data;
            if (wr_en && wr_addr == 2) m_hi = wr_data;
            if (wr_en && wr_addr == 3) m_tgt = wr_data;
            if (acc) m_busy = 1; else if (conv_done) m_busy = 0;
            m_iss = flush ? 0 : m_iss + int'(acc);
            m_sto = flush ? 0 : m_sto + int'(push);
            if (flush) mq.delete();
            else begin
                if (pop) void'(mq.pop_front());
                if (push) mq.push_back(int'(conv_data));
            end
            m_hf = hf_n; m_eoa = eoa_n; m_ovr = ovr_n;
            m_tprev = trig_in; m_eprev = ext_pace; m_start = acc; m_ticks = nt;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit sel_f, irq_e;
            case (m_sel)
                0: sel_f = m_hf;
                1: sel_f = m_ovr;
                2: sel_f = m_eoa;
                default: sel_f = mq.size() > 0;
            endcase
            irq_e = (m_irqen && sel_f) || (m_eoaie && m_eoa);
            chk(conv_start == m_start, "R3 conv_start", conv_start, m_start);
            chk(fifo_count == mq.size(), "R8 fifo_count", fifo_count, mq.size());
            chk(fifo_empty == (mq.size() == 0), "R8 fifo_empty", fifo_empty, mq.size() == 0);
            if (mq.size() > 0) chk(fifo_dout == mq[0], "R8 fifo_dout", fifo_dout, mq[0]);
            chk(hf_flag == m_hf, "R9 hf_flag", hf_flag, m_hf);
            chk(eoa_flag == m_eoa, "R10 eoa_flag", eoa_flag, m_eoa);
            chk(ovr_flag == m_ovr, "R7 ovr_flag", ovr_flag, m_ovr);
            chk(eoc == !m_busy, "R13 eoc", eoc, !m_busy);
            chk(irq == irq_e, "R11 irq", irq, irq_e);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic conv1();
        wr(6, 16'hBEEF);
        idle(LAT + 3);
    endtask

    task automatic drain();
        int n;
        @(negedge clk);
        n = fifo_count;
        fifo_rd = 1;
        repeat (n) @(negedge clk);
        fifo_rd = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        int s0;
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset state
        chk(conv_start == 0, "R1 start", conv_start, 0);
        chk(fifo_empty == 1, "R1 empty", fifo_empty, 1);
        chk(hf_flag == 0 && eoa_flag == 0 && ovr_flag == 0, "R1 flags", {hf_flag, eoa_flag, ovr_flag}, 0);
        chk(irq == 0 && eoc == 1, "R1 irq/eoc", {irq, eoc}, 1);

        // R2 trigger source 00 blocks software starts
        s0 = n_starts;
        conv1();
        chk(n_starts == s0, "R2 no start", n_starts - s0, 0);

        // R3 software conversions
        wr(0, 4);
        s0 = n_starts;
        conv1(); conv1(); conv1();
        chk(n_starts - s0 == 3, "R3 starts", n_starts - s0, 3);
        chk(fifo_count == 3, "R3 stored", fifo_count, 3);

        // R13 and R7 overrun while busy
        s0 = n_starts;
        wr(6, 0);
        chk(eoc == 0, "R13 busy", eoc, 0);
        wr(6, 0);
        idle(LAT + 3);
        chk(n_starts - s0 == 1, "R7 single start", n_starts - s0, 1);
        chk(ovr_flag == 1, "R7 overrun", ovr_flag, 1);
        wr(4, 4);
        idle(1);
        chk(ovr_flag == 0, "R12 clear overrun", ovr_flag, 0);
        drain();
        wr(5, 0);
        idle(1);
        chk(fifo_empty == 1, "R12 flush", fifo_empty, 1);

        // R4 internal pacer, 3*4 ticks
        wr(0, 0);
        wr(1, 3); wr(2, 4);
        s0 = n_starts;
        wr(0, 4 | 1);
        idle(607);
        chk(n_starts - s0 == 10, "R4 pacer count", n_starts - s0, 10);
        wr(0, 1);
        idle(LAT + 3);
        drain();

        // R4 zero divisor counts as 65536
        wr(1, 0); wr(2, 1);
        fast_ref = 1;
        wr(5, 0);
        s0 = n_starts;
        wr(0, 4 | 1);
        idle(65000);
        chk(n_starts == s0, "R4 zero divisor early", n_starts - s0, 0);
        idle(1000);
        chk(n_starts - s0 == 1, "R4 zero divisor", n_starts - s0, 1);
        wr(0, 1);
        fast_ref = 0;
        idle(LAT + 3);
        drain();

        // R5 external pacer
        wr(5, 0);
        s0 = n_starts;
        wr(0, 4 | 2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) ext_pace = 1;
            idle(10);
            @(negedge clk) ext_pace = 0;
            idle(10);
        end
        chk(n_starts - s0 == 4, "R5 external", n_starts - s0, 4);
        wr(0, 2);
        drain();

        // R6 arm and trigger
        wr(0, 4 | 16);
        s0 = n_starts;
        conv1();
        chk(n_starts == s0, "R6 unarmed", n_starts - s0, 0);
        @(negedge clk) trig_in = 1;
        idle(2);
        @(negedge clk) trig_in = 0;
        conv1();
        chk(n_starts - s0 == 1, "R6 armed", n_starts - s0, 1);
        drain();

        // R9 half-full and R8 full
        wr(5, 0);
        wr(4, 7);
        wr(0, 4);
        for (int i = 0; i < 255; i++) conv1();
        chk(fifo_count == 255 && hf_flag == 0, "R9 below half", hf_flag, 0);
        conv1();
        chk(hf_flag == 1, "R9 half-full", hf_flag, 1);
        @(negedge clk) fifo_rd = 1;
        repeat (250) @(negedge clk);
        fifo_rd = 0;
        idle(2);
        chk(hf_flag == 1, "R9 held after drain", hf_flag, 1);
        wr(4, 1);
        idle(1);
        chk(hf_flag == 0, "R12 clear half-full", hf_flag, 0);
        for (int i = 0; i < 506; i++) conv1();
        chk(fifo_count == 512 && ovr_flag == 0, "R8 full", fifo_count, 512);
        conv1();
        chk(ovr_flag == 1 && fifo_count == 512, "R8 drop when full", ovr_flag, 1);
        drain();
        chk(fifo_empty == 1, "R8 drained", fifo_empty, 1);

        // R10 end of acquisition
        wr(5, 0);
        wr(4, 7);
        wr(3, 3);
        wr(0, 4 | 32);
        s0 = n_starts;
        for (int i = 0; i < 5; i++) conv1();
        chk(n_starts - s0 == 3, "R10 starts stop", n_starts - s0, 3);
        chk(eoa_flag == 1 && irq == 1, "R10 flag and irq", {eoa_flag, irq}, 3);

        // R11 general source select
        wr(0, 4 | 64 | (3 << 7));
        idle(1);
        chk(irq == 1, "R11 not-empty source", irq, 1);
        wr(0, 4);
        idle(1);
        chk(irq == 0, "R11 all disabled", irq, 0);
        wr(0, 4 | 64 | (2 << 7));
        idle(1);
        chk(irq == 1, "R11 eoa via general", irq, 1);

        idle(5);
        finish_run();
    end
endmodule